// File: doc/BRIEF.md
# Privileged model-register access controller

This block executes register read and write requests that an instruction pipeline issues for model-specific control registers. Each request carries a 32-bit index, a write value given as two 32-bit halves, and the requester's current privilege level. The controller checks privilege first, then decodes the index. It applies the presence straps, the read-only, lock and canonical-address rules, and it returns either read data split into halves or a general-protection fault.

The block holds a small bank of scratch registers to exercise these rules: system-call selector and targets, segment bases, fast-entry stack and entry point, a flag mask, an auxiliary timestamp word and a lockable feature-control word. A window of virtualization capability registers returns computed constants. The `cfg_ignore_unknown` input selects what happens to unclaimed indices.

Index map (default parameters): 0x100 call selector, 0x101 call target, 0x102 compat call target, 0x103 flag mask, 0x104 segment base A, 0x105 segment base B, 0x106 swap segment base, 0x107 timestamp aux, 0x108 entry stack, 0x109 entry point, 0x180 feature control, 0x200–0x20B capability registers.

Top module: `sysreg_access_ctrl`

## Requirements
- R1: A request with `req_priv` other than 0 faults, whatever its index, and changes no register.
- R2: A write value is {`req_wdata_hi`,`req_wdata_lo`}. Every request produces exactly one `rsp_valid` pulse in the cycle after it, and read data comes back as `rsp_rdata_hi`/`rsp_rdata_lo`.
- R3: An unclaimed index faults when `cfg_ignore_unknown` is 0. When it is 1, a read returns zero without a fault and a write completes without a fault and changes nothing.
- R4: An index whose strap is low behaves as unclaimed. `feat_fastcall` gates 0x100, 0x108 and 0x109, `feat_wide` gates 0x101–0x106, `feat_tsaux` gates 0x107 and `feat_virt` gates the capability window.
- R5: Feature control (0x180) keeps only the low 32 bits, so the high half reads 0. After a write sets its bit 0 (lock), every later write to it faults and leaves it unchanged. Reads stay allowed.
- R6: A write to 0x101, 0x102, 0x104–0x106, 0x108 or 0x109 faults unless bits 63:47 of the value are all equal. 0x100 accepts any value.
- R7: Capability register n (index 0x200+n, n in 0..11) reads hi = 0xCAB00000+n and lo = 0x00001000+n. Any write to it faults.
- R8: The flag mask (0x103) and timestamp aux (0x107) keep only the low 32 bits of a write, and their high half reads 0.
- R9: A faulting response carries zero read data, and a faulting write leaves the target register unchanged.
- R10: After reset no response is pending and every stored register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_wdata_lo | input | 32 | Write value bits 31:0 |
| req_wdata_hi | input | 32 | Write value bits 63:32 |
| req_priv | input | 2 | Current privilege level |
| cfg_ignore_unknown | input | 1 | Treat unclaimed indices as harmless |
| feat_fastcall | input | 1 | Call selector and fast-entry registers present |
| feat_wide | input | 1 | Wide-mode targets and segment bases present |
| feat_tsaux | input | 1 | Timestamp aux register present |
| feat_virt | input | 1 | Capability window present |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | General-protection fault |
| rsp_rdata_lo | output | 32 | Read data bits 31:0 |
| rsp_rdata_hi | output | 32 | Read data bits 63:32 |

## Verification
On every cycle the assertions check the response timing (one pulse per request, none when idle), that a request from a nonzero privilege level faults, and that faulting responses carry zero data. They also check that each canonical-rule register only ever holds a canonical value, and that the feature-control word stays frozen once its lock bit is set. Only the bench scenarios can show the index map, the capability constants, the high-half truncation of narrow registers, and the ignore-unknown option in both settings. The same holds for strap removal that later restores the earlier contents, and for read-back of accepted and rejected writes.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int IDX_W     = 32;
  localparam int HALF_W    = 32;
  localparam int DATA_W    = 2 * HALF_W;
  localparam int CANON_MSB = 47;
  localparam int CAP_COUNT = 12;
  localparam int CAP_SEL_W = 4;

  typedef enum logic [3:0] {
    SL_SC_SEL   = 4'd0,
    SL_SC_TGT   = 4'd1,
    SL_SC_CMP   = 4'd2,
    SL_FMASK    = 4'd3,
    SL_SEG_A    = 4'd4,
    SL_SEG_B    = 4'd5,
    SL_SEG_SWAP = 4'd6,
    SL_TS_AUX   = 4'd7,
    SL_ENT_STK  = 4'd8,
    SL_ENT_PC   = 4'd9,
    SL_FEATCTL  = 4'd10,
    SL_NONE     = 4'd15
  } slot_e;

  localparam int NUM_SLOTS = 11;
  localparam int SYS_SPAN  = 10;

  typedef enum logic [1:0] {
    CL_UNKNOWN = 2'd0,
    CL_STORE   = 2'd1,
    CL_CAP     = 2'd2
  } class_e;

  typedef struct packed {
    class_e               cls;
    slot_e                slot;
    logic                 canon;
    logic [CAP_SEL_W-1:0] cap_sel;
  } dec_t;

  function automatic logic is_narrow(int s);
    return (s == int'(SL_FMASK)) || (s == int'(SL_TS_AUX)) || (s == int'(SL_FEATCTL));
  endfunction

  function automatic logic is_canon_slot(int s);
    return (s == int'(SL_SC_TGT)) || (s == int'(SL_SC_CMP)) || (s == int'(SL_SEG_A)) ||
           (s == int'(SL_SEG_B)) || (s == int'(SL_SEG_SWAP)) || (s == int'(SL_ENT_STK)) ||
           (s == int'(SL_ENT_PC));
  endfunction

  function automatic logic [DATA_W-1:0] cap_value(logic [CAP_SEL_W-1:0] sel);
    return {32'hCAB0_0000 | {28'h0, sel}, 32'h0000_1000 | {28'h0, sel}};
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter logic [IDX_W-1:0] SYS_BASE = 32'h0000_0100,
  parameter logic [IDX_W-1:0] FEAT_IDX = 32'h0000_0180,
  parameter logic [IDX_W-1:0] CAP_BASE = 32'h0000_0200
) (
  input  logic [IDX_W-1:0] index,
  input  logic             feat_fastcall,
  input  logic             feat_wide,
  input  logic             feat_tsaux,
  input  logic             feat_virt,
  output dec_t             dec
);
  logic [IDX_W-1:0] sys_off;
  logic [IDX_W-1:0] cap_off;
  slot_e            sys_slot;
  logic             present;

  assign sys_off  = index - SYS_BASE;
  assign cap_off  = index - CAP_BASE;
  assign sys_slot = slot_e'(sys_off[3:0]);

  always_comb begin
    case (sys_slot)
      SL_SC_SEL, SL_ENT_STK, SL_ENT_PC: present = feat_fastcall;
      SL_TS_AUX:                        present = feat_tsaux;
      default:                          present = feat_wide;
    endcase
  end

  always_comb begin
    dec = '{cls: CL_UNKNOWN, slot: SL_NONE, canon: 1'b0, cap_sel: '0};
    if (sys_off < IDX_W'(SYS_SPAN)) begin
      if (present) begin
        dec.cls   = CL_STORE;
        dec.slot  = sys_slot;
        dec.canon = is_canon_slot(int'(sys_slot));
      end
    end else if (index == FEAT_IDX) begin
      dec.cls  = CL_STORE;
      dec.slot = SL_FEATCTL;
    end else if (cap_off < IDX_W'(CAP_COUNT) && feat_virt) begin
      dec.cls     = CL_CAP;
      dec.cap_sel = cap_off[CAP_SEL_W-1:0];
    end
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_e             wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  slot_e             rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);
  logic [DATA_W-1:0] bank [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic we;
    assign we = wr_en && (wr_slot == slot_e'(s));

    if (is_narrow(s)) begin : g_narrow
      logic [HALF_W-1:0] q, d;
      always_comb d = we ? wr_data[HALF_W-1:0] : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign bank[s] = {{HALF_W{1'b0}}, q};
    end else begin : g_wide
      logic [DATA_W-1:0] q, d;
      always_comb d = we ? wr_data : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign bank[s] = q;

      if (is_canon_slot(s)) begin : g_canon
        // R6
        canon_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (&q[DATA_W-1:CANON_MSB]) || !(|q[DATA_W-1:CANON_MSB]));
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (rd_slot == slot_e'(s)) rd_data = bank[s];
  end

  assign locked = bank[SL_FEATCTL][0];

  // R5
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(bank[SL_FEATCTL]));
endmodule

// File: rtl/sysreg_access_ctrl.sv
module sysreg_access_ctrl
  import sysreg_pkg::*;
#(
  parameter logic [IDX_W-1:0] SYS_BASE = 32'h0000_0100,
  parameter logic [IDX_W-1:0] FEAT_IDX = 32'h0000_0180,
  parameter logic [IDX_W-1:0] CAP_BASE = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [HALF_W-1:0] req_wdata_lo,
  input  logic [HALF_W-1:0] req_wdata_hi,
  input  logic [1:0]        req_priv,
  input  logic              cfg_ignore_unknown,
  input  logic              feat_fastcall,
  input  logic              feat_wide,
  input  logic              feat_tsaux,
  input  logic              feat_virt,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [HALF_W-1:0] rsp_rdata_lo,
  output logic [HALF_W-1:0] rsp_rdata_hi
);
  dec_t              dec;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] store_rd;
  logic              locked;
  logic              canon_ok;
  logic              wr_en;
  logic              fault_d;
  logic [DATA_W-1:0] data_d;
  logic              valid_q, fault_q;
  logic [DATA_W-1:0] data_q;

  sysreg_decode #(.SYS_BASE(SYS_BASE), .FEAT_IDX(FEAT_IDX), .CAP_BASE(CAP_BASE)) u_decode (
    .index         (req_index),
    .feat_fastcall (feat_fastcall),
    .feat_wide     (feat_wide),
    .feat_tsaux    (feat_tsaux),
    .feat_virt     (feat_virt),
    .dec           (dec)
  );

  sysreg_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (dec.slot),
    .wr_data (wdata),
    .rd_slot (dec.slot),
    .rd_data (store_rd),
    .locked  (locked)
  );

  assign wdata    = {req_wdata_hi, req_wdata_lo};
  assign canon_ok = (&wdata[DATA_W-1:CANON_MSB]) || !(|wdata[DATA_W-1:CANON_MSB]);

  always_comb begin
    fault_d = 1'b0;
    data_d  = '0;
    wr_en   = 1'b0;
    if (req_valid) begin
      if (req_priv != 2'd0) begin
        fault_d = 1'b1;
      end else begin
        case (dec.cls)
          CL_STORE: begin
            if (req_write) begin
              if (dec.slot == SL_FEATCTL && locked) fault_d = 1'b1;
              else if (dec.canon && !canon_ok)       fault_d = 1'b1;
              else                                   wr_en   = 1'b1;
            end else begin
              data_d = store_rd;
            end
          end
          CL_CAP: begin
            if (req_write) fault_d = 1'b1;
            else           data_d  = cap_value(dec.cap_sel);
          end
          default: fault_d = !cfg_ignore_unknown;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        fault_q <= fault_d;
        data_q  <= data_d;
      end
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_fault    = fault_q;
  assign rsp_rdata_lo = data_q[HALF_W-1:0];
  assign rsp_rdata_hi = data_q[DATA_W-1:HALF_W];

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != 2'd0) |=> rsp_fault);
  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_rdata_lo == '0 && rsp_rdata_hi == '0));
  // R7
  cap_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_priv == 2'd0 && dec.cls == CL_CAP) |=> rsp_fault);
endmodule

// File: tb/sysreg_access_ctrl_bench.sv
module sysreg_access_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_index, req_wdata_lo, req_wdata_hi;
  logic [1:0]  req_priv;
  logic        cfg_ignore_unknown;
  logic        feat_fastcall, feat_wide, feat_tsaux, feat_virt;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata_lo, rsp_rdata_hi;

  int checks = 0;
  int fails  = 0;
  bit timed_out = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  sysreg_access_ctrl u_sysreg_access_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_index(req_index), .req_wdata_lo(req_wdata_lo), .req_wdata_hi(req_wdata_hi),
    .req_priv(req_priv), .cfg_ignore_unknown(cfg_ignore_unknown),
    .feat_fastcall(feat_fastcall), .feat_wide(feat_wide), .feat_tsaux(feat_tsaux),
    .feat_virt(feat_virt), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata_lo(rsp_rdata_lo), .rsp_rdata_hi(rsp_rdata_hi)
  );

  task automatic rq(input bit wr, input logic [31:0] idx, input logic [31:0] hi,
                    input logic [31:0] lo, input logic [1:0] pl, input bit ef,
                    input logic [31:0] eh, input logic [31:0] el, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx;
    req_wdata_hi = hi; req_wdata_lo = lo; req_priv = pl;
    exp_q.push_back({ef, eh, el});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: response with no request, actual fault=%0b expected none", rsp_fault);
      end else begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_fault, rsp_rdata_hi, rsp_rdata_lo} !== e) begin
          fails++;
          $display("FAIL %s: actual fault=%0b data=%h_%h expected fault=%0b data=%h_%h",
                   t, rsp_fault, rsp_rdata_hi, rsp_rdata_lo, e[64], e[63:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
    req_wdata_lo = '0; req_wdata_hi = '0; req_priv = '0;
    cfg_ignore_unknown = 1'b0;
    feat_fastcall = 1'b1; feat_wide = 1'b1; feat_tsaux = 1'b1; feat_virt = 1'b1;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
          fails++;
          $display("FAIL R10: rsp_valid=%0b after reset expected 0", rsp_valid);
        end
        // R10 registers read zero after reset
        rq(0, 32'h101, 0, 0, 0, 0, 0, 0, "R10");
        rq(0, 32'h180, 0, 0, 0, 0, 0, 0, "R10");
        // R2 back-to-back write and read of halves
        rq(1, 32'h100, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, "R2");
        rq(0, 32'h100, 0, 0, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, "R2");
        // R6 canonical positive, negative, and rejected
        rq(1, 32'h101, 32'h0000_7FFF, 32'hAAAA_0000, 0, 0, 0, 0, "R6");
        rq(1, 32'h104, 32'hFFFF_8000, 32'h0000_0042, 0, 0, 0, 0, "R6");
        rq(1, 32'h101, 32'h0000_8000, 32'h0, 0, 1, 0, 0, "R6");
        rq(0, 32'h101, 0, 0, 0, 0, 32'h0000_7FFF, 32'hAAAA_0000, "R9");
        rq(0, 32'h104, 0, 0, 0, 0, 32'hFFFF_8000, 32'h0000_0042, "R6");
        rq(1, 32'h109, 32'h1234_0000, 32'h0, 0, 1, 0, 0, "R6");
        // R1 privilege
        rq(0, 32'h101, 0, 0, 3, 1, 0, 0, "R1");
        rq(1, 32'h101, 32'h0, 32'h5, 1, 1, 0, 0, "R1");
        rq(0, 32'h101, 0, 0, 0, 0, 32'h0000_7FFF, 32'hAAAA_0000, "R1");
        // R8 narrow registers
        rq(1, 32'h103, 32'hFFFF_FFFF, 32'h0000_0300, 0, 0, 0, 0, "R8");
        rq(1, 32'h107, 32'h1111_1111, 32'h8765_4321, 0, 0, 0, 0, "R8");
        rq(0, 32'h103, 0, 0, 0, 0, 0, 32'h0000_0300, "R8");
        rq(0, 32'h107, 0, 0, 0, 0, 0, 32'h8765_4321, "R8");
        // R7 capability window
        rq(0, 32'h200, 0, 0, 0, 0, 32'hCAB0_0000, 32'h0000_1000, "R7");
        rq(0, 32'h20B, 0, 0, 0, 0, 32'hCAB0_000B, 32'h0000_100B, "R7");
        rq(1, 32'h205, 0, 1, 0, 1, 0, 0, "R7");
        rq(0, 32'h20C, 0, 0, 0, 1, 0, 0, "R3");
        // R5 feature control lock
        rq(1, 32'h180, 32'hFFFF_0000, 32'h0000_0004, 0, 0, 0, 0, "R5");
        rq(0, 32'h180, 0, 0, 0, 0, 0, 32'h0000_0004, "R5");
        rq(1, 32'h180, 32'h0, 32'h0000_0005, 0, 0, 0, 0, "R5");
        rq(1, 32'h180, 32'h0, 32'h0000_0000, 0, 1, 0, 0, "R5");
        rq(0, 32'h180, 0, 0, 0, 0, 0, 32'h0000_0005, "R5");
        // R3 unknown index
        rq(0, 32'h0555, 0, 0, 0, 1, 0, 0, "R3");
        rq(1, 32'h0555, 0, 7, 0, 1, 0, 0, "R3");
        idle();
        cfg_ignore_unknown = 1'b1;
        rq(0, 32'h0555, 0, 0, 0, 0, 0, 0, "R3");
        rq(1, 32'h0555, 32'h9, 32'h9, 0, 0, 0, 0, "R3");
        rq(0, 32'h0555, 0, 0, 0, 0, 0, 0, "R3");
        idle();
        // R4 strap removal
        cfg_ignore_unknown = 1'b0;
        feat_wide = 1'b0; feat_virt = 1'b0;
        rq(0, 32'h104, 0, 0, 0, 1, 0, 0, "R4");
        rq(1, 32'h104, 32'h0, 32'h77, 0, 1, 0, 0, "R4");
        rq(0, 32'h200, 0, 0, 0, 1, 0, 0, "R4");
        rq(0, 32'h100, 0, 0, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, "R4");
        idle();
        cfg_ignore_unknown = 1'b1;
        rq(0, 32'h104, 0, 0, 0, 0, 0, 0, "R4");
        idle();
        cfg_ignore_unknown = 1'b0;
        feat_wide = 1'b1; feat_virt = 1'b1; feat_tsaux = 1'b0;
        rq(0, 32'h104, 0, 0, 0, 0, 32'hFFFF_8000, 32'h0000_0042, "R4");
        rq(0, 32'h107, 0, 0, 0, 1, 0, 0, "R4");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
          fails++;
          $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
        end
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL R2: watchdog expired, actual hung expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule